// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block is the digital control store for a crosspoint matrix of 16 rows by 8 columns. It holds one enable bit per crosspoint, 128 bits in all. A row field and a column field together select one bit. That bit is loaded from a single data input whenever chip select and the strobe are both high. The 128 enable levels leave the block as one vector. Each bit drives the switch that joins one row to one column. The store is write-only and has no read path.

The block has no clock. Each bit is a level-sensitive latch. The latch is open while its decoded address, chip select and the strobe are all true, and the data input flows straight through to the switch while it is open. The bit keeps the level that the data input had when the strobe fell. An active-high clear acts at once on all 128 bits and wins over any write. Chip select lets several such stores share the address, data and strobe wiring while only one of them answers.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `clr` is high, every bit of `sw_on` is 0.
- R2: `clr` clears all bits regardless of `sel` and `stb`, including while `sel`, `stb` and `din` are all high.
- R3: With `sel` low, pulsing `stb` leaves all of `sw_on` unchanged, whatever `din` does.
- R4: While `sel` and `stb` are high and `clr` is low, the addressed bit follows `din` level for level.
- R5: After `stb` falls, the addressed bit keeps the `din` value it had at that falling edge, even if `din` changes later.
- R6: A write with `din` = 1 turns the addressed crosspoint on, and a write with `din` = 0 turns it off.
- R7: A write changes only the addressed bit. The other 127 bits keep their values.
- R8: Row `x` and column `y` select bit `x*8+y` of `sw_on`. For example, row 5, column 3 is bit 43.
- R9: If `clr` falls while `sel` and `stb` are high, the addressed bit immediately follows `din`, and all other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr | input | 1 | Asynchronous clear of all bits, active high |
| sel | input | 1 | Chip select, active high |
| stb | input | 1 | Write strobe, active high; the latch closes on its falling edge |
| din | input | 1 | Level written to the addressed bit |
| row_addr | input | 4 | Row field of the address (0 to 15) |
| col_addr | input | 3 | Column field of the address (0 to 7) |
| sw_on | output | 128 | Switch enables, bit `row*8+col` |

## Verification
Two functions can act in the same instant: the clear and an open write. This happens when `clr` is raised while `sel`, `stb` and `din` are all high, and again when `clr` is released with the strobe still high. The bench first toggles `din` with the clear held and checks that the whole vector stays at zero. It then drops `clr` with the latch open and checks two things: the addressed bit must take `din` at once, and every other bit must stay cleared. The bit must then keep its value after `stb` falls.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int DEF_ROWS = 16;
  localparam int DEF_COLS = 8;

  // Row-major placement of one crosspoint in the enable vector
  function automatic int cell_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode #(
  parameter int ROWS = xpt_pkg::DEF_ROWS,
  parameter int COLS = xpt_pkg::DEF_COLS,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CELLS = ROWS * COLS
) (
  input  logic             sel,
  input  logic             stb,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  output logic [CELLS-1:0] open_en
);
  logic gate;
  assign gate = sel & stb;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_hit;
    assign row_hit = (row_addr == ROW_W'(r));
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign open_en[xpt_pkg::cell_index(r, c, COLS)] =
        gate & row_hit & (col_addr == COL_W'(c));
    end
  end
endmodule

// File: rtl/xpt_latch_cell.sv
module xpt_latch_cell (
  input  logic clr,
  input  logic open_en,
  input  logic d,
  output logic q
);
  // Clear has priority; transparent while enabled
  always_latch begin
    if (clr)
      q = 1'b0;
    else if (open_en)
      q = d;
  end
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int ROWS = xpt_pkg::DEF_ROWS,
  parameter int COLS = xpt_pkg::DEF_COLS,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CELLS = ROWS * COLS
) (
  input  logic             clr,
  input  logic             sel,
  input  logic             stb,
  input  logic             din,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  output logic [CELLS-1:0] sw_on
);
  logic [CELLS-1:0] open_en;

  xpt_addr_decode #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .sel      (sel),
    .stb      (stb),
    .row_addr (row_addr),
    .col_addr (col_addr),
    .open_en  (open_en)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    xpt_latch_cell u_cell (
      .clr     (clr),
      .open_en (open_en[i]),
      .d       (din),
      .q       (sw_on[i])
    );
  end
endmodule

// File: rtl/xpt_ctrl_mem_chk.sv
module xpt_ctrl_mem_chk #(
  parameter int ROWS = xpt_pkg::DEF_ROWS,
  parameter int COLS = xpt_pkg::DEF_COLS,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CELLS = ROWS * COLS,
  localparam int IDX_W = $clog2(CELLS)
) (
  input logic             clr,
  input logic             sel,
  input logic             stb,
  input logic             din,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic [CELLS-1:0] sw_on
);
  logic [IDX_W-1:0] cur_idx;
  logic [CELLS-1:0] cur_mask;
  assign cur_idx  = IDX_W'(row_addr) * IDX_W'(COLS) + IDX_W'(col_addr);
  assign cur_mask = CELLS'(1) << cur_idx;

  // Last captured write, taken at a strobe fall with select high
  logic             cap_vld;
  logic [IDX_W-1:0] cap_idx;
  logic             cap_dat;
  always_ff @(negedge stb or posedge clr) begin
    if (clr) begin
      cap_vld <= 1'b0;
      cap_idx <= '0;
      cap_dat <= 1'b0;
    end else if (sel) begin
      cap_vld <= 1'b1;
      cap_idx <= cur_idx;
      cap_dat <= din;
    end
  end

  // Image of the vector at the strobe rise
  logic             snap_vld;
  logic [CELLS-1:0] snap;
  always_ff @(posedge stb or posedge clr) begin
    if (clr) begin
      snap_vld <= 1'b0;
      snap     <= '0;
    end else begin
      snap_vld <= 1'b1;
      snap     <= sw_on;
    end
  end

  // R4: addressed bit equals din just before the strobe falls
  a_r4_follow_din: assert property (@(negedge stb) disable iff (clr)
    sel |-> (sw_on[cur_idx] == din));

  // R5: captured level still held at the next strobe rise
  a_r5_hold_value: assert property (@(posedge stb) disable iff (clr)
    cap_vld |-> (sw_on[cap_idx] == cap_dat));

  // R7: bits outside the addressed one do not move during a strobe
  a_r7_others_kept: assert property (@(negedge stb) disable iff (clr)
    snap_vld |-> (((sw_on ^ snap) & ~cur_mask) == '0));

  // R3: a deselected strobe changes nothing
  a_r3_deselect_quiet: assert property (@(negedge stb) disable iff (clr)
    (snap_vld && !sel) |-> (sw_on == snap));

  // R1: vector is empty when the clear is released with no open write
  always_ff @(negedge clr) begin
    if (!(sel && stb))
      a_r1_clear_empty: assert (sw_on == '0);
  end
endmodule

bind xpt_ctrl_mem xpt_ctrl_mem_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clr      (clr),
  .sel      (sel),
  .stb      (stb),
  .din      (din),
  .row_addr (row_addr),
  .col_addr (col_addr),
  .sw_on    (sw_on)
);

// File: tb/xpt_ctrl_mem_test.sv
`timescale 1ns/1ps
module xpt_ctrl_mem_test;
  localparam int N = 128;

  logic         clk = 1'b0;
  logic         clr, sel, stb, din;
  logic [3:0]   row_addr;
  logic [2:0]   col_addr;
  logic [N-1:0] sw_on;
  logic [N-1:0] mdl;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpt_ctrl_mem uut (
    .clr(clr), .sel(sel), .stb(stb), .din(din),
    .row_addr(row_addr), .col_addr(col_addr), .sw_on(sw_on)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse(input int r, input int c, input logic d, input logic s);
    row_addr = 4'(r); col_addr = 3'(c); sel = s; din = d;
    #3 stb = 1'b1;
    #3 stb = 1'b0;
    #3 sel = 1'b0;
    if (s) mdl[r*8+c] = d;
  endtask

  task automatic t_reset_state;
    #10 chk("R1 reset state", sw_on, '0);
    clr = 1'b0;
    #5 chk("R1 after release", sw_on, '0);
  endtask

  task automatic t_basic_writes;
    pulse(0, 0, 1'b1, 1'b1);  chk("R6 on r0c0", sw_on, mdl);
    pulse(15, 7, 1'b1, 1'b1); chk("R7 r15c7 others kept", sw_on, mdl);
    pulse(5, 3, 1'b1, 1'b1);  chk1("R8 r5c3 is bit 43", sw_on[43], 1'b1);
    chk("R7 after r5c3", sw_on, mdl);
    pulse(9, 0, 1'b1, 1'b1);  chk1("R8 r9c0 is bit 72", sw_on[72], 1'b1);
    pulse(15, 7, 1'b0, 1'b1); chk("R6 off r15c7", sw_on, mdl);
  endtask

  task automatic t_transparency;
    row_addr = 4'd2; col_addr = 3'd6; sel = 1'b1; din = 1'b0;
    #3 stb = 1'b1;
    #3 chk1("R4 follow 0", sw_on[22], 1'b0);
    din = 1'b1; #3 chk1("R4 follow 1", sw_on[22], 1'b1);
    din = 1'b0; #3 chk1("R4 follow back 0", sw_on[22], 1'b0);
    din = 1'b1; #3 stb = 1'b0;
    #3 din = 1'b0;
    #3 chk1("R5 hold 1", sw_on[22], 1'b1);
    mdl[22] = 1'b1;
    chk("R7 during transparent write", sw_on, mdl);
    din = 1'b1; #3 stb = 1'b1;
    #3 din = 1'b0; #3 stb = 1'b0;
    #3 din = 1'b1;
    #3 chk1("R5 hold 0", sw_on[22], 1'b0);
    mdl[22] = 1'b0;
    sel = 1'b0;
  endtask

  task automatic t_deselect;
    pulse(5, 3, 1'b0, 1'b0);  chk("R3 no clear when deselected", sw_on, mdl);
    pulse(1, 1, 1'b1, 1'b0);  chk("R3 no set when deselected", sw_on, mdl);
    row_addr = 4'd1; col_addr = 3'd1; sel = 1'b0; din = 1'b0;
    #3 stb = 1'b1;
    din = 1'b1; #3 chk("R3 toggle while deselected", sw_on, mdl);
    din = 1'b0; #3 stb = 1'b0;
    #3 chk("R3 after deselected strobe", sw_on, mdl);
  endtask

  task automatic t_clear_overlap;
    clr = 1'b1;
    #3 chk("R2 clear with sel low", sw_on, '0);
    clr = 1'b0; mdl = '0;
    #3;
    pulse(3, 3, 1'b1, 1'b1);
    pulse(12, 1, 1'b1, 1'b1);
    chk("R6 rebuilt pattern", sw_on, mdl);
    row_addr = 4'd7; col_addr = 3'd4; sel = 1'b1; din = 1'b1;
    #3 stb = 1'b1;
    #3 clr = 1'b1;
    #3 chk("R2 clear beats open write", sw_on, '0);
    din = 1'b0; #3 din = 1'b1;
    #3 chk("R2 din toggled under clear", sw_on, '0);
    clr = 1'b0;
    #1 chk("R9 open write after clear release", sw_on, N'(1) << 60);
    din = 1'b0; #3 chk("R9 follows din after release", sw_on, '0);
    din = 1'b1; #3 stb = 1'b0;
    #3 din = 1'b0; sel = 1'b0;
    #3 chk("R9 held after strobe fall", sw_on, N'(1) << 60);
  endtask

  initial begin
    clr = 1'b1; sel = 1'b0; stb = 1'b0; din = 1'b0;
    row_addr = '0; col_addr = '0; mdl = '0;
    t_reset_state();
    t_basic_writes();
    t_transparency();
    t_deselect();
    t_clear_overlap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule